// File: doc/BRIEF.md
# Bus-Aware Reset and Standby Entry Sequencer

This block turns two asynchronous system requests, one for an initialising reset and one for hardware standby, into the signals that put the chip into reset or standby. A single software-writable mode bit picks how entry happens. With the bit clear, entry follows the request straight away. With the bit set, the sequencer first raises a hold that keeps new bus transactions from starting. It then waits for the bus to report idle, and only then asserts the chosen entry signal.

Both requests cross into the clock domain through two flip-flops each. A three-state controller (idle, draining, asserted) reacts to the synchronised values. If both requests are pending together, reset wins over standby. An entry output stays high until the request that caused it is withdrawn.

Top module: `rst_stby_seq`

## Requirements
- R1: The mode bit reads 0 after the initialising reset (rst_n low). When mode_we_i is high at a rising edge, mode_o shows mode_wdata_i after that edge. Mode 0 selects immediate entry and mode 1 selects synchronous entry.
- R2: Each request input passes through two flops. A request first held high before edge N can change the outputs after edge N+2 at the earliest.
- R3: In mode 0, an idle sequencer that sees a synchronised request asserts the matching entry output after the next edge, whatever bus_busy_i is doing.
- R4: In mode 1, an idle sequencer that sees a synchronised request raises bus_hold_o after the next edge and asserts no entry output. It asserts the matching entry output after the first edge at which it is draining and bus_busy_i is low.
- R5: When both synchronised requests are high at the moment of decision (in idle or while draining), enter_reset_o is the one asserted. A reset request that arrives while a standby is draining turns the pending entry into reset.
- R6: An asserted entry output stays high while its own synchronised request stays high. It drops after the edge at which that request is seen low. While an entry is asserted, the other request has no effect.
- R7: enter_reset_o and enter_stby_o are never high together, and bus_hold_o is high whenever either one is high.
- R8: If both synchronised requests are low while draining, the sequencer returns to idle, bus_hold_o drops and no entry output is asserted.
- R9: The mode is sampled only when the idle sequencer accepts a request. Rewriting it while draining or asserted does not change the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Initialising reset, active low, asynchronous |
| init_req_i | input | 1 | Initialising-reset request, asynchronous |
| stby_req_i | input | 1 | Hardware-standby request, asynchronous |
| mode_we_i | input | 1 | Write strobe for the mode bit |
| mode_wdata_i | input | 1 | Value written to the mode bit (1 = wait for bus idle) |
| bus_busy_i | input | 1 | High while any bus access is outstanding |
| mode_o | output | 1 | Current mode bit |
| enter_reset_o | output | 1 | Reset entry asserted |
| enter_stby_o | output | 1 | Standby entry asserted |
| bus_hold_o | output | 1 | Blocks new bus transactions while entry is pending or active |

## Verification
The bench compares every cycle against a behavioural model that delays the requests through a two-deep queue. It targets these cases: a reset request arriving during a standby drain, which a design without the upgrade would answer by entering standby; both requests rising in the same cycle, which catches inverted priority; and a reset request during an asserted standby, which must be ignored until standby is released and then acted on. Further cases cover a request dropped mid-drain, which must return to idle without entering, and a mode rewrite during a drain, which a design that reads the mode live would answer by asserting entry while the bus is still busy. Off-by-one latency in the synchroniser shows up as a mismatch on the cycle the outputs first change.

// File: rtl/rst_stby_seq.sv
module rst_stby_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req_i,
  input  logic stby_req_i,
  input  logic mode_we_i,
  input  logic mode_wdata_i,
  input  logic bus_busy_i,
  output logic mode_o,
  output logic enter_reset_o,
  output logic enter_stby_o,
  output logic bus_hold_o
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DRAIN = 2'd1, S_ASSERT = 2'd2} st_t;

  logic [1:0] init_ff, stby_ff;
  logic       init_s, stby_s, any_s;
  logic       mode_q, tgt_rst;
  st_t        st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_ff <= 2'b00;
      stby_ff <= 2'b00;
    end else begin
      init_ff <= {init_ff[0], init_req_i};
      stby_ff <= {stby_ff[0], stby_req_i};
    end

  assign init_s = init_ff[1];
  assign stby_s = stby_ff[1];
  assign any_s  = init_s | stby_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         mode_q <= 1'b0;
    else if (mode_we_i) mode_q <= mode_wdata_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      tgt_rst <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (any_s) begin
            tgt_rst <= init_s;
            st      <= mode_q ? S_DRAIN : S_ASSERT;
          end
        S_DRAIN:
          if (!any_s) st <= S_IDLE;
          else begin
            tgt_rst <= init_s;
            if (!bus_busy_i) st <= S_ASSERT;
          end
        S_ASSERT:
          if (tgt_rst ? !init_s : !stby_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  assign mode_o        = mode_q;
  assign enter_reset_o = (st == S_ASSERT) &&  tgt_rst;
  assign enter_stby_o  = (st == S_ASSERT) && !tgt_rst;
  assign bus_hold_o    = (st != S_IDLE);

  // R7
  excl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_reset_o && enter_stby_o));

  // R7
  hold_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_reset_o || enter_stby_o) |-> bus_hold_o);

  // R4
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && bus_busy_i) |=> !(enter_reset_o || enter_stby_o));

  // R6
  rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_reset_o && init_s) |=> enter_reset_o);

  // R6
  stby_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_stby_o && stby_s) |=> enter_stby_o);

  // R1
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we_i |=> (mode_o == $past(mode_wdata_i)));

  // R3
  fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !mode_q && any_s) |=> (enter_reset_o || enter_stby_o));

endmodule

// File: tb/sim_rst_stby_seq.sv
module sim_rst_stby_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, stby_req = 1'b0, mode_we = 1'b0, mode_wd = 1'b0, busy = 1'b0;
  logic mode_o, ent_rst, ent_stby, hold;

  always #2.5 clk = ~clk;

  rst_stby_seq u0 (
    .clk(clk), .rst_n(rst_n), .init_req_i(init_req), .stby_req_i(stby_req),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd), .bus_busy_i(busy),
    .mode_o(mode_o), .enter_reset_o(ent_rst), .enter_stby_o(ent_stby), .bus_hold_o(hold)
  );

  int    n_chk = 0, n_bad = 0, cyc_cnt = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural model: phase 0 idle, 1 waiting for bus, 2 in entry
  bit iq[$];
  bit sq[$];
  int ph = 0;
  bit m_rst = 0, m_mode = 0;

  task automatic model_reset();
    iq = '{0, 0};
    sq = '{0, 0};
    ph = 0; m_rst = 0; m_mode = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit a, b;
    if (!rst_n) model_reset();
    else begin
      a = iq[0]; b = sq[0];
      if (ph == 0) begin
        if (a || b) begin m_rst = a; ph = m_mode ? 1 : 2; end
      end else if (ph == 1) begin
        if (!(a || b)) ph = 0;
        else begin m_rst = a; if (!busy) ph = 2; end
      end else begin
        if (m_rst ? !a : !b) ph = 0;
      end
      if (mode_we) m_mode = mode_wd;
      void'(iq.pop_front()); iq.push_back(init_req);
      void'(sq.pop_front()); sq.push_back(stby_req);
    end
    #1;
    if (rst_n && !done) begin
      logic [3:0] exp_v, got_v;
      exp_v = {m_mode, ph == 2 && m_rst, ph == 2 && !m_rst, ph != 0};
      got_v = {mode_o, ent_rst, ent_stby, hold};
      n_chk++;
      if (exp_v !== got_v) begin
        n_bad++;
        $display("FAIL %s cycle %0d: {mode,rst,stby,hold} got %b expected %b", tag, cyc_cnt, got_v, exp_v);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(bit v);
    @(negedge clk); mode_we = 1; mode_wd = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic expect_out(string t, bit r, bit s, bit h);
    n_chk++;
    if ({ent_rst, ent_stby, hold} !== {r, s, h}) begin
      n_bad++;
      $display("FAIL %s: {rst,stby,hold} got %b expected %b", t, {ent_rst, ent_stby, hold}, {r, s, h});
    end
  endtask

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    tag = "R1";
    n_chk++;
    if ({mode_o, ent_rst, ent_stby, hold} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1 reset: got %b expected 0000", {mode_o, ent_rst, ent_stby, hold});
    end
    write_mode(1); step(1);
    write_mode(0); step(2);

    // R2 R3: immediate reset entry while bus busy, exact latency
    tag = "R3"; busy = 1;
    @(negedge clk); init_req = 1;
    step(2); expect_out("R2 not yet", 0, 0, 0);
    step(1); expect_out("R2 entry", 1, 0, 1);
    step(4);
    tag = "R6"; init_req = 0;
    step(2); expect_out("R6 still held", 1, 0, 1);
    step(1); expect_out("R6 release", 0, 0, 0);
    step(2);

    // immediate standby
    tag = "R3"; busy = 0;
    @(negedge clk); stby_req = 1;
    step(5); expect_out("R3 standby", 0, 1, 1);
    stby_req = 0; step(5);

    // R5 both at once
    tag = "R5";
    @(negedge clk); stby_req = 1; init_req = 1;
    step(3); expect_out("R5 priority", 1, 0, 1);
    init_req = 0; stby_req = 0; step(5);

    // R6 reset during asserted standby is ignored until standby drops
    tag = "R6";
    @(negedge clk); stby_req = 1;
    step(4);
    init_req = 1; step(5);
    expect_out("R6 ignore other", 0, 1, 1);
    stby_req = 0; step(8);
    expect_out("R6 reset after standby", 1, 0, 1);
    init_req = 0; step(5);

    // R4 synchronous standby with long busy
    write_mode(1); step(1);
    tag = "R4"; busy = 1;
    @(negedge clk); stby_req = 1;
    step(3); expect_out("R4 hold only", 0, 0, 1);
    step(5); busy = 0;
    step(1); expect_out("R4 entry", 0, 1, 1);
    stby_req = 0; step(5);

    // R5 reset upgrades a draining standby
    tag = "R5"; busy = 1;
    @(negedge clk); stby_req = 1;
    step(5); init_req = 1;
    step(4); busy = 0;
    step(1); expect_out("R5 upgrade", 1, 0, 1);
    stby_req = 0; init_req = 0; step(5);

    // R8 request withdrawn while draining
    tag = "R8"; busy = 1;
    @(negedge clk); init_req = 1;
    step(5); init_req = 0;
    step(3); expect_out("R8 abort", 0, 0, 0);
    busy = 0; step(3);

    // R9 mode rewrite while draining
    tag = "R9"; busy = 1;
    @(negedge clk); init_req = 1;
    step(4);
    write_mode(0);
    step(4); expect_out("R9 still draining", 0, 0, 1);
    busy = 0; step(1); expect_out("R9 entry", 1, 0, 1);
    init_req = 0; step(5);

    // synchronous mode, bus already idle
    write_mode(1);
    tag = "R4"; busy = 0;
    @(negedge clk); init_req = 1;
    step(3); expect_out("R4 one drain cycle", 0, 0, 1);
    step(1); expect_out("R4 idle-bus entry", 1, 0, 1);
    init_req = 0; step(4);

    // pulsed requests and busy toggling, model-checked every cycle
    tag = "R7";
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      busy = (i % 3) != 0;
      if (i % 17 == 0) stby_req = ~stby_req;
      if (i % 29 == 5) init_req = ~init_req;
      if (i % 41 == 7) begin mode_we = 1; mode_wd = ~mode_o; end
      else mode_we = 0;
    end
    mode_we = 0; init_req = 0; stby_req = 0; busy = 0;
    step(6);
    finish_run();
  end
endmodule